// File: doc/BRIEF.md
# Transmit Queue Scheduler with Completion Log

This block holds pending transmit requests for a CAN controller and decides which one goes on the bus next. Each request carries an 11-bit identifier and a small buffer handle that points at the payload held elsewhere. Requests sit in a fixed set of slots. A mode input picks the selection policy. In arrival order, requests leave in the order they came in. In identifier priority, the pending request with the lowest identifier wins, which matches how bus arbitration ranks frames.

The transmit engine sees the current pick on the dequeue port and claims it with a start pulse. From that point the pick is frozen until the engine reports done or abort. A done frees the slot and logs the identifier into a completion FIFO of up to 32 entries. An abort frees the slot and logs nothing. Software drains the completion FIFO through a pop port. A watermark on the FIFO's fill level drives an interrupt line.

Top module: `can_txq_sched`

## Requirements
- R1: After reset no slot is occupied, and `tx_valid`, `tx_active`, `enq_busy`, `evt_valid`, `evt_ovf` and `evt_wm_irq` are all 0.
- R2: An enqueue (`enq_valid` high while `enq_busy` is low) stores the identifier and handle in the lowest-numbered free slot, and `tx_valid` is high from the next cycle on.
- R3: `enq_busy` is high while all slots are occupied. An enqueue made while it is high is dropped and changes no slot.
- R4: With `mode_prio` = 0, requests are presented in the order they were enqueued.
- R5: With `mode_prio` = 1, the pending request with the numerically lowest identifier is presented. When identifiers are equal, the lowest slot index wins.
- R6: A `tx_start` while `tx_valid` is high claims the presented request. `tx_active` then goes high, `tx_valid` goes low, and `tx_id`, `tx_handle` and `tx_slot` stay fixed until `tx_done` or `tx_abort`, even when a better request arrives in the meantime.
- R7: `tx_done` during an active transmission frees the slot and pushes its identifier into the completion FIFO. `tx_abort` frees the slot without pushing. If both are high, done takes precedence.
- R8: The completion FIFO returns identifiers in completion order. `evt_valid` is high while the FIFO is non-empty, and `evt_pop` removes the head entry.
- R9: A completion that arrives while the FIFO holds 32 entries is dropped, and `evt_ovf` goes high and stays high until reset.
- R10: The effective watermark is `evt_wm_cfg` limited to 32. `evt_wm_irq` is high when the effective watermark is non-zero and `evt_count` is at least that value. A setting of 0 keeps the interrupt off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_prio | input | 1 | 0 = arrival order, 1 = lowest identifier first |
| enq_valid | input | 1 | Enqueue request |
| enq_id | input | 11 | Identifier of the new request |
| enq_handle | input | 4 | Buffer handle of the new request |
| enq_busy | output | 1 | All slots occupied; enqueue refused |
| tx_valid | output | 1 | A request is presented and may be claimed |
| tx_id | output | 11 | Identifier of the presented or active request |
| tx_handle | output | 4 | Handle of the presented or active request |
| tx_slot | output | 3 | Slot of the presented or active request |
| tx_start | input | 1 | Engine claims the presented request |
| tx_done | input | 1 | Active transmission completed |
| tx_abort | input | 1 | Active transmission abandoned |
| tx_active | output | 1 | A claimed transmission is in progress |
| evt_pop | input | 1 | Remove the head completion entry |
| evt_valid | output | 1 | Completion FIFO non-empty |
| evt_id | output | 11 | Identifier at the completion FIFO head |
| evt_count | output | 6 | Completion FIFO fill level |
| evt_ovf | output | 1 | Sticky completion-drop flag |
| evt_wm_cfg | input | 8 | Watermark setting, clamped to 32 |
| evt_wm_irq | output | 1 | Watermark interrupt |

## Verification
The bench enqueues equal identifiers in priority mode. A selector with the wrong tie-break would present the higher slot first, and one that used a non-strict compare would pick the last match. It drops a lower identifier into the queue during an active transmission, which catches a design that re-selects mid-frame and hands the engine a changed handle. It fills the completion log to 33 entries, so an off-by-one full test either wraps over the head entry or never raises the drop flag. The watermark table probes 0, exact matches, one-below values and settings above 32, which catches a missing clamp or a `>` written where `>=` belongs.

// File: rtl/txq_pkg.sv
package txq_pkg;

  // Clamp a watermark setting to the FIFO depth
  function automatic int unsigned wm_clamp(input int unsigned cfg, input int unsigned depth);
    return (cfg > depth) ? depth : cfg;
  endfunction

  // Interrupt condition for a given fill level and clamped watermark
  function automatic logic wm_reached(input int unsigned fill, input int unsigned eff);
    return (eff != 0) && (fill >= eff);
  endfunction

endpackage

// File: rtl/txq_slots.sv
module txq_slots #(
  parameter int NSLOT = 8,
  parameter int ID_W  = 11,
  parameter int H_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_prio,
  input  logic                     enq_valid,
  input  logic [ID_W-1:0]          enq_id,
  input  logic [H_W-1:0]           enq_handle,
  output logic                     busy,
  output logic                     sel_valid,
  output logic [ID_W-1:0]          sel_id,
  output logic [H_W-1:0]           sel_handle,
  output logic [$clog2(NSLOT)-1:0] sel_slot,
  input  logic                     start,
  input  logic                     done,
  input  logic                     abort,
  output logic                     active,
  output logic                     cpl_fire,
  output logic [ID_W-1:0]          cpl_id
);
  localparam int SW = $clog2(NSLOT);
  localparam int AW = (SW < 1) ? 1 : SW;
  localparam logic [AW-1:0] AGE_MAX = AW'(NSLOT - 1);

  logic [NSLOT-1:0] occ_q;
  logic [ID_W-1:0]  id_q  [NSLOT];
  logic [H_W-1:0]   h_q   [NSLOT];
  logic [AW-1:0]    age_q [NSLOT];
  logic             act_q;
  logic [SW-1:0]    act_slot_q;

  // internal events, named for the assertions
  logic          enq_take;
  logic          claim;
  logic          finish;
  logic [SW-1:0] free_idx;
  logic          any_pend;
  logic [SW-1:0] best_idx;

  assign busy     = &occ_q;
  assign enq_take = enq_valid && !busy;
  assign finish   = act_q && (done || abort);
  assign cpl_fire = act_q && done;
  assign cpl_id   = id_q[act_slot_q];

  always_comb begin
    free_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!occ_q[i]) free_idx = SW'(i);
    end
  end

  // oldest entry (arrival mode) or lowest identifier (priority mode);
  // strict compares keep the lowest slot index on a tie
  always_comb begin
    any_pend = 1'b0;
    best_idx = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (occ_q[i]) begin
        if (!any_pend) begin
          any_pend = 1'b1;
          best_idx = SW'(i);
        end else if (mode_prio ? (id_q[i] < id_q[best_idx])
                               : (age_q[i] > age_q[best_idx])) begin
          best_idx = SW'(i);
        end
      end
    end
  end

  assign sel_valid  = any_pend && !act_q;
  assign sel_slot   = act_q ? act_slot_q : best_idx;
  assign sel_id     = id_q[sel_slot];
  assign sel_handle = h_q[sel_slot];
  assign active     = act_q;
  assign claim      = sel_valid && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      act_slot_q <= '0;
    end else if (claim) begin
      act_q      <= 1'b1;
      act_slot_q <= best_idx;
    end else if (finish) begin
      act_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ_q[g] <= 1'b0;
        id_q[g]  <= '0;
        h_q[g]   <= '0;
        age_q[g] <= '0;
      end else begin
        if (enq_take && free_idx == SW'(g)) begin
          occ_q[g] <= 1'b1;
          id_q[g]  <= enq_id;
          h_q[g]   <= enq_handle;
          age_q[g] <= '0;
        end else begin
          if (enq_take && occ_q[g] && age_q[g] != AGE_MAX) age_q[g] <= age_q[g] + 1'b1;
          if (finish && act_slot_q == SW'(g)) occ_q[g] <= 1'b0;
        end
      end
    end
  end

  // R6: the claimed request is held until done or abort
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !done && !abort) |=> (act_q && $stable(sel_slot) && $stable(sel_id)));
  // R6: nothing is presented for claiming while a transmission runs
  a_r6_no_present: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> !sel_valid);
  // R3: an enqueue into a full queue does not touch occupancy
  a_r3_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && busy && !finish) |=> ($countones(occ_q) == NSLOT));
  // R7: completing or aborting frees exactly one slot when nothing is enqueued
  a_r7_free: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !enq_valid) |=> ($countones(occ_q) == $countones($past(occ_q)) - 1));

endmodule

// File: rtl/txq_evt_fifo.sv
module txq_evt_fifo #(
  parameter int DEPTH = 32,
  parameter int D_W   = 11,
  parameter int WM_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [D_W-1:0]             push_data,
  input  logic                       pop,
  input  logic [WM_W-1:0]            wm_cfg,
  output logic                       valid,
  output logic [D_W-1:0]             head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       ovf,
  output logic                       wm_irq
);
  import txq_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [D_W-1:0] mem [DEPTH];
  logic [PW-1:0]  wr_q, rd_q;
  logic [CW-1:0]  cnt_q;
  logic           ovf_q;

  logic full, do_push, do_pop, drop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign drop    = push && full;
  assign do_pop  = pop && (cnt_q != '0);

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (do_push) wr_q <= ptr_next(wr_q);
      if (do_pop)  rd_q <= ptr_next(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
      if (drop) ovf_q <= 1'b1;
    end
  end

  assign valid  = (cnt_q != '0);
  assign head   = mem[rd_q];
  assign count  = cnt_q;
  assign ovf    = ovf_q;
  assign wm_irq = wm_reached(int'(cnt_q), wm_clamp(int'(wm_cfg), DEPTH));

  // R9: a dropped completion raises the sticky flag and leaves the level full
  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !pop) |=> (ovf && count == CW'(DEPTH)));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R8: the fill level never exceeds the depth
  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R10: a zero setting keeps the interrupt off
  a_r10_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_cfg == '0) |-> !wm_irq);

endmodule

// File: rtl/can_txq_sched.sv
module can_txq_sched #(
  parameter int NSLOT     = 8,
  parameter int ID_W      = 11,
  parameter int H_W       = 4,
  parameter int EVT_DEPTH = 32,
  parameter int WM_W      = 8,
  localparam int SW = $clog2(NSLOT),
  localparam int CW = $clog2(EVT_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_prio,
  input  logic            enq_valid,
  input  logic [ID_W-1:0] enq_id,
  input  logic [H_W-1:0]  enq_handle,
  output logic            enq_busy,
  output logic            tx_valid,
  output logic [ID_W-1:0] tx_id,
  output logic [H_W-1:0]  tx_handle,
  output logic [SW-1:0]   tx_slot,
  input  logic            tx_start,
  input  logic            tx_done,
  input  logic            tx_abort,
  output logic            tx_active,
  input  logic            evt_pop,
  output logic            evt_valid,
  output logic [ID_W-1:0] evt_id,
  output logic [CW-1:0]   evt_count,
  output logic            evt_ovf,
  input  logic [WM_W-1:0] evt_wm_cfg,
  output logic            evt_wm_irq
);
  logic            cpl_fire;
  logic [ID_W-1:0] cpl_id;

  txq_slots #(.NSLOT(NSLOT), .ID_W(ID_W), .H_W(H_W)) slots_i (
    .clk(clk), .rst_n(rst_n), .mode_prio(mode_prio),
    .enq_valid(enq_valid), .enq_id(enq_id), .enq_handle(enq_handle),
    .busy(enq_busy), .sel_valid(tx_valid), .sel_id(tx_id),
    .sel_handle(tx_handle), .sel_slot(tx_slot),
    .start(tx_start), .done(tx_done), .abort(tx_abort), .active(tx_active),
    .cpl_fire(cpl_fire), .cpl_id(cpl_id)
  );

  txq_evt_fifo #(.DEPTH(EVT_DEPTH), .D_W(ID_W), .WM_W(WM_W)) log_i (
    .clk(clk), .rst_n(rst_n), .push(cpl_fire), .push_data(cpl_id),
    .pop(evt_pop), .wm_cfg(evt_wm_cfg), .valid(evt_valid), .head(evt_id),
    .count(evt_count), .ovf(evt_ovf), .wm_irq(evt_wm_irq)
  );

  // R7: an abort never adds a completion entry
  a_r7_abort_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && tx_abort && !tx_done && !evt_pop) |=> $stable(evt_count));

endmodule

// File: tb/can_txq_sched_tb_top.sv
module can_txq_sched_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic mode_prio, enq_valid, tx_start, tx_done, tx_abort, evt_pop;
  logic [10:0] enq_id;
  logic [3:0]  enq_handle;
  logic [7:0]  evt_wm_cfg;
  logic enq_busy, tx_valid, tx_active, evt_valid, evt_ovf, evt_wm_irq;
  logic [10:0] tx_id, evt_id;
  logic [3:0]  tx_handle;
  logic [2:0]  tx_slot;
  logic [5:0]  evt_count;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  can_txq_sched dut_i (
    .clk(clk), .rst_n(rst_n), .mode_prio(mode_prio), .enq_valid(enq_valid),
    .enq_id(enq_id), .enq_handle(enq_handle), .enq_busy(enq_busy),
    .tx_valid(tx_valid), .tx_id(tx_id), .tx_handle(tx_handle), .tx_slot(tx_slot),
    .tx_start(tx_start), .tx_done(tx_done), .tx_abort(tx_abort), .tx_active(tx_active),
    .evt_pop(evt_pop), .evt_valid(evt_valid), .evt_id(evt_id), .evt_count(evt_count),
    .evt_ovf(evt_ovf), .evt_wm_cfg(evt_wm_cfg), .evt_wm_irq(evt_wm_irq)
  );

  // {watermark setting, completions to log, expected interrupt}
  localparam logic [15:0] WM_TAB [8] = '{
    {8'd0,   7'd5,  1'b0}, {8'd5,   7'd5,  1'b1}, {8'd6,   7'd5,  1'b0},
    {8'd1,   7'd1,  1'b1}, {8'd32,  7'd32, 1'b1}, {8'd200, 7'd32, 1'b1},
    {8'd200, 7'd31, 1'b0}, {8'd33,  7'd31, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; enq_valid = 0; tx_start = 0; tx_done = 0; tx_abort = 0; evt_pop = 0;
    enq_id = '0; enq_handle = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic enq(input int id, input int h);
    enq_valid = 1; enq_id = 11'(id); enq_handle = 4'(h);
    @(negedge clk);
    enq_valid = 0;
  endtask

  // claim the presented request and complete it; returns what was presented
  task automatic send(output int id, output int h);
    id = int'(tx_id); h = int'(tx_handle);
    tx_start = 1; @(negedge clk);
    tx_start = 0; tx_done = 1; @(negedge clk);
    tx_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    int id, h;
    mode_prio = 0; evt_wm_cfg = 8'd0;
    do_reset();

    // R1 reset state
    check("R1 tx_valid", tx_valid, 0);
    check("R1 busy/active", {enq_busy, tx_active}, 0);
    check("R1 evt flags", {evt_valid, evt_ovf, evt_wm_irq}, 0);

    // R2 first enqueue lands in slot 0
    enq(100, 3);
    check("R2 tx_valid", tx_valid, 1);
    check("R2 tx_slot", tx_slot, 0);
    check("R2 tx_id", tx_id, 100);

    // R3 fill remaining 7 slots, then extra is refused
    for (int k = 1; k < 8; k++) enq(100 + k, k + 3);
    check("R3 busy", enq_busy, 1);
    enq(5, 15);
    check("R3 refused keeps head", tx_id, 100);

    // R4 arrival order drains 100..107, refused id 5 never appears
    for (int k = 0; k < 8; k++) begin
      send(id, h);
      check("R4 fifo order", id, 100 + k);
    end
    check("R3 refused not queued", tx_valid, 0);
    check("R7 done logged 8", evt_count, 8);

    // R8 completion order
    for (int k = 0; k < 8; k++) begin
      check("R8 head", evt_id, 100 + k);
      evt_pop = 1; @(negedge clk); evt_pop = 0;
    end
    check("R8 empty", evt_valid, 0);

    // R4 arrival order with refill after a removal
    enq(30, 1); enq(10, 2);
    send(id, h); check("R4 oldest first", id, 30);
    enq(5, 3);
    send(id, h); check("R4 older than newcomer", id, 10);
    send(id, h); check("R4 last", id, 5);

    // R5 priority with a tie on identifier 3 (slots 1 and 2)
    do_reset();
    mode_prio = 1;
    enq(5, 1); enq(3, 2); enq(3, 4); enq(7, 6);
    send(id, h); check("R5 lowest id", id, 3); check("R5 tie low slot", h, 2);
    send(id, h); check("R5 tie second", h, 4);
    send(id, h); check("R5 then 5", id, 5);
    send(id, h); check("R5 then 7", id, 7);

    // R6 freeze: claim id 9, then enqueue id 1 during transmission
    enq(9, 9);
    tx_start = 1; @(negedge clk); tx_start = 0;
    check("R6 active", tx_active, 1);
    check("R6 not presented", tx_valid, 0);
    enq(1, 11);
    check("R6 id held", tx_id, 9);
    check("R6 handle held", tx_handle, 9);
    // R7 abort frees without logging
    tx_abort = 1; @(negedge clk); tx_abort = 0;
    check("R7 abort no log", evt_count, 4);
    check("R7 abort freed", tx_id, 1);
    send(id, h); check("R7 after abort", id, 1);

    // R9 overflow: 33 completions from empty log
    do_reset();
    mode_prio = 0;
    for (int k = 0; k < 33; k++) begin enq(200 + k, 0); send(id, h); end
    check("R9 count held", evt_count, 32);
    check("R9 ovf", evt_ovf, 1);
    check("R9 head kept", evt_id, 200);
    evt_pop = 1; @(negedge clk); evt_pop = 0;
    check("R9 ovf sticky", evt_ovf, 1);

    // R10 watermark table
    foreach (WM_TAB[v]) begin
      do_reset();
      evt_wm_cfg = WM_TAB[v][15:8];
      for (int k = 0; k < int'(WM_TAB[v][7:1]); k++) begin enq(k, 0); send(id, h); end
      check($sformatf("R10 wm=%0d fill=%0d", WM_TAB[v][15:8], WM_TAB[v][7:1]),
            evt_wm_irq, WM_TAB[v][0]);
    end

    report();
    $finish;
  end
endmodule